// File: doc/BRIEF.md
# Interrupt Priority Status Word Unit

This block holds the 8-bit processor status word of a small core and decides, every cycle, whether one of the maskable interrupt requests may be accepted. Each request carries a 2-bit priority level (0 is the most urgent). A 2-bit in-service field inside the status word acts as a threshold: only requests whose level is at or below it numerically are accepted. The global enable flag gates all of them. When a request is accepted, the block pulses an acknowledge with the winning request index, presents the old status byte for the core to push on its stack, clears the enable flag and reloads the in-service field from the accepted level. All of this happens on one clock edge.

The core drives the other updates through strobes: enable, disable, software break, push, restore (used for every return and for pop), full byte writes, single-bit writes and an arithmetic flag port. The flag port updates only zero, auxiliary carry and carry. Instruction decoding, the stack memory and the vector fetch sit outside this block.

Top module: `irq_psw_unit`

## Requirements
- R1: Reset (active-low `rst_n`) sets the status word to 8'h06. The bit positions are: bit 7 enable (IE), bit 6 zero, bit 5 bank select high, bit 4 auxiliary carry, bit 3 bank select low, bits 2:1 in-service field (ISP), bit 0 carry.
- R2: `ack_o` is high only when IE is 1 and at least one request has `req_i[i]`=1 and level `req_lvl_i[2i+1:2i]` numerically less than or equal to ISP. With IE=0, or with no permitted request, `ack_o` stays 0.
- R3: Among permitted requests, the one with the lowest level wins, and a tie goes to the lowest index. `ack_idx_o` gives that index in the same cycle as `ack_o`.
- R4: On the clock edge that ends an acknowledge cycle, IE becomes 0 and ISP is loaded from the accepted level: level 3 gives 2'b10, level 2 gives 2'b01, and level 1 or 0 gives 2'b00. All other bits are kept. The acknowledge lasts one cycle.
- R5: In a cycle with an acknowledge, `brk_i` or `push_i`, `save_valid_o` is 1 and `save_data_o` equals the status word from before that edge. A break also clears IE at the edge. A push leaves the word unchanged.
- R6: `restore_i` loads all 8 bits from `restore_data_i` at the next edge and overrides every other event. In a restore cycle `ack_o` is forced to 0, and acceptance is judged on the following cycle against the restored word.
- R7: `ei_i` sets IE and `di_i` clears it. If both are high, the disable wins.
- R8: `wr_byte_i` loads all 8 bits from `wr_data_i`. `bit_wr_i` writes `bit_val_i` into the bit numbered `bit_sel_i`, using the positions of R1. `flag_wr_i` updates only bits 6, 4 and 0 from `flag_z_i`, `flag_ac_i` and `flag_cy_i`. Priority runs disable > enable > byte write > bit write > flag write, and only the highest strobe present takes effect.
- R9: In any cycle with an acknowledge, a break or a restore, enable, disable, byte, bit and flag writes are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_REQ | Maskable interrupt requests |
| req_lvl_i | input | 2*NUM_REQ | Priority level of each request, 2 bits per request |
| ei_i | input | 1 | Set the enable flag |
| di_i | input | 1 | Clear the enable flag |
| brk_i | input | 1 | Software break: save the word, clear the enable flag |
| push_i | input | 1 | Present the status word for saving |
| restore_i | input | 1 | Reload the whole word (return or pop) |
| restore_data_i | input | 8 | Value to reload |
| wr_byte_i | input | 1 | Full byte write strobe |
| wr_data_i | input | 8 | Byte write data |
| bit_wr_i | input | 1 | Single-bit write strobe |
| bit_sel_i | input | 3 | Bit position to write |
| bit_val_i | input | 1 | Value written to that bit |
| flag_wr_i | input | 1 | Arithmetic flag update strobe |
| flag_z_i | input | 1 | New zero flag |
| flag_ac_i | input | 1 | New auxiliary carry flag |
| flag_cy_i | input | 1 | New carry flag |
| ack_o | output | 1 | Interrupt accepted this cycle |
| ack_idx_o | output | clog2(NUM_REQ) | Index of the accepted request |
| save_valid_o | output | 1 | `save_data_o` must be pushed |
| save_data_o | output | 8 | Status byte to save |
| psw_o | output | 8 | Current status word |

## Verification
The bench sweeps every request mask and level combination of a four-request unit against all four threshold settings, and computes the winner and the new in-service field arithmetically. A comparison off by one in the threshold would accept or refuse requests at the boundary level. A tie rule that picks the highest index, or an ISP map that copies the level directly, would show up within the sweep. Directed cases aim at restore and acknowledge in the same cycle, where a wrong design would accept against the stale word. They also cover byte writes hidden under an acknowledge or a break, which a wrong design would let overwrite the cleared flag. Finally they check the save byte, which must carry the word from before IE was cleared.

// File: rtl/irq_psw_pkg.sv
package irq_psw_pkg;

   localparam int PSW_W   = 8;
   localparam int LEVEL_W = 2;

   localparam logic [PSW_W-1:0] PSW_RESET = 8'h06;

   // Field order fixes the bit positions of the word.
   typedef struct packed {
      logic       ie;
      logic       z;
      logic       bank_hi;
      logic       ac;
      logic       bank_lo;
      logic [1:0] isp;
      logic       cy;
   } psw_t;

   // New in-service threshold after accepting a request of a given level.
   function automatic logic [1:0] isp_after_accept(input logic [LEVEL_W-1:0] lvl);
      logic [1:0] r;
      case (lvl)
         2'd3:    r = 2'b10;
         2'd2:    r = 2'b01;
         default: r = 2'b00;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
   import irq_psw_pkg::*;
#(
   parameter int NUM_REQ = 8,
   parameter int LVL_W   = LEVEL_W,
   localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
   input  logic [NUM_REQ-1:0]       req_i,
   input  logic [NUM_REQ*LVL_W-1:0] lvl_flat_i,
   input  logic                     ie_i,
   input  logic [1:0]               isp_i,
   output logic                     grant_o,
   output logic [IDX_W-1:0]         grant_idx_o,
   output logic [LVL_W-1:0]         grant_lvl_o
);

   if (NUM_REQ < 1) begin : g_bad_num
      $error("irq_prio_arb: NUM_REQ must be at least 1");
   end
   if (LVL_W != 2) begin : g_bad_lvl
      $error("irq_prio_arb: LVL_W must equal the 2-bit in-service field");
   end

   logic [LVL_W-1:0]   lvl_arr [NUM_REQ];
   logic [NUM_REQ-1:0] elig;

   for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
      assign lvl_arr[g] = lvl_flat_i[g*LVL_W +: LVL_W];
      // A request is eligible when its level does not exceed the threshold.
      assign elig[g]    = req_i[g] & ie_i & (lvl_arr[g] <= isp_i);
   end

   // Scan from index 0 upward; strict compare keeps the lowest index on ties.
   always_comb begin
      grant_o     = 1'b0;
      grant_idx_o = '0;
      grant_lvl_o = '0;
      for (int i = 0; i < NUM_REQ; i++) begin
         if (elig[i] && (!grant_o || (lvl_arr[i] < grant_lvl_o))) begin
            grant_o     = 1'b1;
            grant_idx_o = IDX_W'(i);
            grant_lvl_o = lvl_arr[i];
         end
      end
   end

endmodule

// File: rtl/irq_psw_reg.sv
module irq_psw_reg
   import irq_psw_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ack_i,
   input  logic [1:0]       ack_lvl_i,
   input  logic             brk_i,
   input  logic             restore_i,
   input  logic [PSW_W-1:0] restore_data_i,
   input  logic             ei_i,
   input  logic             di_i,
   input  logic             wr_byte_i,
   input  logic [PSW_W-1:0] wr_data_i,
   input  logic             bit_wr_i,
   input  logic [2:0]       bit_sel_i,
   input  logic             bit_val_i,
   input  logic             flag_wr_i,
   input  logic             flag_z_i,
   input  logic             flag_ac_i,
   input  logic             flag_cy_i,
   output psw_t             psw_o
);

   psw_t             psw_q;
   psw_t             psw_d;
   logic [PSW_W-1:0] bit_vec;

   always_comb begin
      bit_vec            = psw_q;
      bit_vec[bit_sel_i] = bit_val_i;
   end

   // One priority chain: restore, accept, break, disable, enable, byte, bit, flags.
   always_comb begin
      psw_d = psw_q;
      if (restore_i) begin
         psw_d = psw_t'(restore_data_i);
      end else if (ack_i) begin
         psw_d.ie  = 1'b0;
         psw_d.isp = isp_after_accept(ack_lvl_i);
      end else if (brk_i) begin
         psw_d.ie = 1'b0;
      end else if (di_i) begin
         psw_d.ie = 1'b0;
      end else if (ei_i) begin
         psw_d.ie = 1'b1;
      end else if (wr_byte_i) begin
         psw_d = psw_t'(wr_data_i);
      end else if (bit_wr_i) begin
         psw_d = psw_t'(bit_vec);
      end else if (flag_wr_i) begin
         psw_d.z  = flag_z_i;
         psw_d.ac = flag_ac_i;
         psw_d.cy = flag_cy_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) psw_q <= psw_t'(PSW_RESET);
      else        psw_q <= psw_d;
   end

   assign psw_o = psw_q;

   AST_RESTORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      restore_i |=> (psw_q == psw_t'($past(restore_data_i)))); // R6

   AST_ACK_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !restore_i) |=> !psw_q.ie); // R4

   AST_ACK_ISP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !restore_i) |=> (psw_q.isp == isp_after_accept($past(ack_lvl_i)))); // R4

   AST_BRK_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_i && !restore_i) |=> !psw_q.ie); // R5

   AST_EVENT_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      ((ack_i || brk_i) && !restore_i) |=>
         $stable({psw_q.z, psw_q.bank_hi, psw_q.ac, psw_q.bank_lo, psw_q.cy})); // R9

   AST_EI_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (ei_i && !di_i && !restore_i && !ack_i && !brk_i) |=> psw_q.ie); // R7

endmodule

// File: rtl/irq_psw_unit.sv
module irq_psw_unit
   import irq_psw_pkg::*;
#(
   parameter int NUM_REQ = 8,
   localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_REQ-1:0]         req_i,
   input  logic [NUM_REQ*LEVEL_W-1:0] req_lvl_i,
   input  logic                       ei_i,
   input  logic                       di_i,
   input  logic                       brk_i,
   input  logic                       push_i,
   input  logic                       restore_i,
   input  logic [PSW_W-1:0]           restore_data_i,
   input  logic                       wr_byte_i,
   input  logic [PSW_W-1:0]           wr_data_i,
   input  logic                       bit_wr_i,
   input  logic [2:0]                 bit_sel_i,
   input  logic                       bit_val_i,
   input  logic                       flag_wr_i,
   input  logic                       flag_z_i,
   input  logic                       flag_ac_i,
   input  logic                       flag_cy_i,
   output logic                       ack_o,
   output logic [IDX_W-1:0]           ack_idx_o,
   output logic                       save_valid_o,
   output logic [PSW_W-1:0]           save_data_o,
   output logic [PSW_W-1:0]           psw_o
);

   psw_t               psw;
   logic               grant;
   logic [IDX_W-1:0]   grant_idx;
   logic [LEVEL_W-1:0] grant_lvl;

   irq_prio_arb #(
      .NUM_REQ (NUM_REQ),
      .LVL_W   (LEVEL_W)
   ) u_arb (
      .req_i       (req_i),
      .lvl_flat_i  (req_lvl_i),
      .ie_i        (psw.ie),
      .isp_i       (psw.isp),
      .grant_o     (grant),
      .grant_idx_o (grant_idx),
      .grant_lvl_o (grant_lvl)
   );

   // A restore in the same cycle defers acceptance to the restored word.
   assign ack_o     = grant & ~restore_i;
   assign ack_idx_o = grant_idx;

   irq_psw_reg u_reg (
      .clk            (clk),
      .rst_n          (rst_n),
      .ack_i          (ack_o),
      .ack_lvl_i      (grant_lvl),
      .brk_i          (brk_i),
      .restore_i      (restore_i),
      .restore_data_i (restore_data_i),
      .ei_i           (ei_i),
      .di_i           (di_i),
      .wr_byte_i      (wr_byte_i),
      .wr_data_i      (wr_data_i),
      .bit_wr_i       (bit_wr_i),
      .bit_sel_i      (bit_sel_i),
      .bit_val_i      (bit_val_i),
      .flag_wr_i      (flag_wr_i),
      .flag_z_i       (flag_z_i),
      .flag_ac_i      (flag_ac_i),
      .flag_cy_i      (flag_cy_i),
      .psw_o          (psw)
   );

   assign psw_o        = psw;
   assign save_valid_o = ~restore_i & (ack_o | brk_i | push_i);
   assign save_data_o  = save_valid_o ? psw_o : '0;

   AST_ACK_PERMITTED: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> (psw_o[7] && req_i[ack_idx_o] &&
                 (req_lvl_i[int'(ack_idx_o)*LEVEL_W +: LEVEL_W] <= psw_o[2:1]))); // R2

   AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |=> !ack_o); // R4

   AST_NO_ACK_ON_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
      restore_i |-> !ack_o); // R6

   AST_PUSH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !restore_i && !ack_o && !brk_i && !ei_i && !di_i &&
       !wr_byte_i && !bit_wr_i && !flag_wr_i) |=> $stable(psw_o)); // R5

endmodule

// File: tb/tb_irq_psw_unit.sv
`timescale 1ns/1ps
module tb_irq_psw_unit;

   localparam int NREQ = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NREQ-1:0] req_i = '0;
   logic [2*NREQ-1:0] req_lvl_i = '0;
   logic ei_i = 0, di_i = 0, brk_i = 0, push_i = 0, restore_i = 0;
   logic [7:0] restore_data_i = '0;
   logic wr_byte_i = 0;
   logic [7:0] wr_data_i = '0;
   logic bit_wr_i = 0;
   logic [2:0] bit_sel_i = '0;
   logic bit_val_i = 0, flag_wr_i = 0, flag_z_i = 0, flag_ac_i = 0, flag_cy_i = 0;
   logic ack_o;
   logic [1:0] ack_idx_o;
   logic save_valid_o;
   logic [7:0] save_data_o, psw_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #10 clk = ~clk;

   irq_psw_unit #(.NUM_REQ(NREQ)) dut (.*);

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [1:0] exp_isp(input logic [1:0] l);
      return (l == 2'd3) ? 2'b10 : (l == 2'd2) ? 2'b01 : 2'b00;
   endfunction

   task automatic idle();
      req_i = '0; ei_i = 0; di_i = 0; brk_i = 0; push_i = 0; restore_i = 0;
      wr_byte_i = 0; bit_wr_i = 0; flag_wr_i = 0;
   endtask

   task automatic set_psw(input logic [7:0] v);
      @(negedge clk); idle(); wr_byte_i = 1; wr_data_i = v;
      @(negedge clk); idle();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [7:0] exp;
      // R1: reset value and stability across release
      repeat (3) @(negedge clk);
      chk(psw_o == 8'h06, "R1 reset value", psw_o, 8'h06);
      rst_n = 1;
      @(negedge clk);
      chk(psw_o == 8'h06, "R1 after release", psw_o, 8'h06);

      // R2: IE=0 blocks even level 0 requests
      req_i = 4'hF; req_lvl_i = 8'h00; #1;
      chk(ack_o == 0, "R2 no ack with IE clear", ack_o, 0);
      @(negedge clk); idle();

      // R7: enable, then both strobes
      ei_i = 1; @(negedge clk); idle();
      chk(psw_o == 8'h86, "R7 ei sets IE", psw_o, 8'h86);
      ei_i = 1; di_i = 1; @(negedge clk); idle();
      chk(psw_o == 8'h06, "R7 di wins over ei", psw_o, 8'h06);

      // R8: byte, bit and flag writes, and their priority
      set_psw(8'h5A);
      chk(psw_o == 8'h5A, "R8 byte write", psw_o, 8'h5A);
      bit_wr_i = 1; bit_sel_i = 3'd0; bit_val_i = 1; @(negedge clk); idle();
      chk(psw_o == 8'h5B, "R8 bit set", psw_o, 8'h5B);
      bit_wr_i = 1; bit_sel_i = 3'd6; bit_val_i = 0; @(negedge clk); idle();
      chk(psw_o == 8'h1B, "R8 bit clear", psw_o, 8'h1B);
      exp = (8'h1B & ~8'h51) | 8'h40;
      flag_wr_i = 1; flag_z_i = 1; flag_ac_i = 0; flag_cy_i = 0; @(negedge clk); idle();
      chk(psw_o == exp, "R8 flag write", psw_o, exp);
      wr_byte_i = 1; wr_data_i = 8'h24; bit_wr_i = 1; bit_sel_i = 3'd7; bit_val_i = 1;
      @(negedge clk); idle();
      chk(psw_o == 8'h24, "R8 byte over bit", psw_o, 8'h24);
      ei_i = 1; wr_byte_i = 1; wr_data_i = 8'h00; @(negedge clk); idle();
      chk(psw_o == 8'hA4, "R8 enable over byte", psw_o, 8'hA4);

      // R5: push saves without change
      set_psw(8'h7E);
      push_i = 1; #1;
      chk(save_valid_o && save_data_o == 8'h7E, "R5 push save", save_data_o, 8'h7E);
      @(negedge clk); idle();
      chk(psw_o == 8'h7E, "R5 push keeps word", psw_o, 8'h7E);

      // R5 R9: break saves old word, clears IE, hides byte write
      set_psw(8'hFF);
      brk_i = 1; wr_byte_i = 1; wr_data_i = 8'h00; #1;
      chk(save_valid_o && save_data_o == 8'hFF, "R5 break save", save_data_o, 8'hFF);
      @(negedge clk); idle();
      chk(psw_o == 8'h7F, "R9 break discards byte write", psw_o, 8'h7F);

      // R6: restore with pending request: deferred, then judged on restored word
      set_psw(8'h86);
      req_i = 4'b0010; req_lvl_i = 8'b00_00_10_00;
      restore_i = 1; restore_data_i = 8'h86; #1;
      chk(ack_o == 0, "R6 no ack in restore cycle", ack_o, 0);
      @(negedge clk); restore_i = 0; #1;
      chk(ack_o == 1 && ack_idx_o == 1, "R6 ack on restored word", {ack_o, ack_idx_o}, 3'b101);
      @(negedge clk); idle();
      chk(psw_o == 8'h02, "R4 isp from level 2", psw_o, 8'h02);
      set_psw(8'h86);
      req_i = 4'b0010; restore_i = 1; restore_data_i = 8'h82;
      @(negedge clk); restore_i = 0; #1;
      chk(ack_o == 0, "R6 restored threshold refuses", ack_o, 0);
      chk(psw_o == 8'h82, "R6 restore loads byte", psw_o, 8'h82);
      @(negedge clk); idle();

      // R9 R5: acknowledge hides a byte write and saves the old word
      set_psw(8'h86);
      req_i = 4'b1000; req_lvl_i = 8'b11_00_00_00; wr_byte_i = 1; wr_data_i = 8'hFF; #1;
      chk(ack_o && ack_idx_o == 3, "R3 single request index", ack_idx_o, 3);
      chk(save_valid_o && save_data_o == 8'h86, "R5 ack save byte", save_data_o, 8'h86);
      @(negedge clk); idle(); #1;
      chk(ack_o == 0, "R4 ack is one cycle", ack_o, 0);
      chk(psw_o == 8'h04, "R9 ack discards byte write", psw_o, 8'h04);

      // R2 R3 R4: sweep of thresholds, levels and request masks
      for (int isp = 0; isp < 4; isp++) begin
         for (int lv = 0; lv < 256; lv++) begin
            for (int m = 0; m < 16; m++) begin
               logic [7:0] base;
               bit wf;
               logic [1:0] wl;
               int wi;
               base = 8'hA8 | 8'(isp << 1);
               @(negedge clk); idle(); wr_byte_i = 1; wr_data_i = base;
               @(negedge clk); idle(); req_i = 4'(m); req_lvl_i = 8'(lv); #1;
               wf = 0; wl = 0; wi = 0;
               for (int i = 0; i < NREQ; i++) begin
                  logic [1:0] l;
                  l = 2'((lv >> (2 * i)) & 3);
                  if (m[i] && (int'(l) <= isp) && (!wf || l < wl)) begin
                     wf = 1; wl = l; wi = i;
                  end
               end
               chk(ack_o == wf, "R2 sweep accept", ack_o, wf);
               if (wf) begin
                  chk(ack_idx_o == wi, "R3 sweep winner", ack_idx_o, wi);
                  exp = (base & ~8'h86) | 8'(exp_isp(wl) << 1);
               end else begin
                  exp = base;
               end
               @(negedge clk); idle(); #1;
               chk(psw_o == exp, "R4 sweep new word", psw_o, exp);
            end
         end
      end
      finish_run();
   end

endmodule